// File: doc/BRIEF.md
# GPIO Output Path with Per-Pin Source Select

This block is the output side of a 16-pin general-purpose I/O bank. It holds one output data word that software never writes directly: a set-mask write forces the masked bits to 1 and a clear-mask write forces the masked bits to 0. Either write leaves every unmasked bit as it was. The stored word is always visible on a readback port, which serves reads of both mask locations.

Each pin has a small configuration word: an output enable, a generated-clock enable with a 2-bit generated-clock select, and a 2-bit lane-clock select. A per-pin multiplexer chooses what the pin carries. The choices are the stored data bit, one of four externally generated clocks, or one of two recovered-lane clock sources. Each lane clock source picks one of four receive-lane clocks and divides it by 2 or by 4. The configuration words are captured into a register every cycle, and reset clears that register, so no pin drives while the bank is in reset.

Top module: `gpo_out_path`

## Requirements
- R1: A cycle with `set_we`=1 makes every bit of `rd_data` whose `set_mask` bit is 1 read 1 from the following clock edge onward.
- R2: A cycle with `clr_we`=1 makes every bit of `rd_data` whose `clr_mask` bit is 1 read 0 from the following clock edge onward.
- R3: When `set_we` and `clr_we` are both 1 in one cycle, a bit named in both masks becomes 0, and bits named only in `set_mask` become 1.
- R4: Bits named by neither active mask keep their value, and masks presented while their write strobe is 0 have no effect on `rd_data`.
- R5: A pin whose captured output enable (`pin_oe` bit) is 0 has `pad_oe`=0 and `pad_out`=0.
- R6: A pin with output enable 1, lane-clock select bit 0 equal to 0 and `pin_cgen`=0 drives its stored data bit, and it follows later changes to that bit.
- R7: A pin with output enable 1, `pin_cgen`=1 and lane-clock select bit 0 equal to 0 carries `gen_clk[k]`, where k is the pin's 2-bit field in `pin_cgsel` (bits 2i+1:2i for pin i).
- R8: The 2-bit lane-clock select of pin i (`pin_lsel` bits 2i+1:2i) means: x0 normal output (data or generated clock), 01 lane clock source 0, 11 lane clock source 1; a lane selection takes priority over `pin_cgen`.
- R9: Lane clock source s divides `lane_clk[p]` by 2 when `lane_div4[s]`=0 and by 4 when it is 1, where p is `lane_pick` bits 2s+1:2s.
- R10: While `rst`=1 the stored data word reads 0 and every `pad_oe` bit is 0, whatever the configuration inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rst | input | 1 | Synchronous active-high reset |
| set_we | input | 1 | Set-mask write strobe |
| set_mask | input | 16 | Bits to force to 1 |
| clr_we | input | 1 | Clear-mask write strobe |
| clr_mask | input | 16 | Bits to force to 0 |
| rd_data | output | 16 | Stored output data word (readback of both mask locations) |
| pin_oe | input | 16 | Per-pin output enable |
| pin_cgen | input | 16 | Per-pin generated-clock enable |
| pin_cgsel | input | 32 | Per-pin generated-clock select, 2 bits per pin |
| pin_lsel | input | 32 | Per-pin lane-clock select, 2 bits per pin |
| gen_clk | input | 4 | Generated clocks |
| lane_clk | input | 4 | Receive-lane clocks |
| lane_pick | input | 4 | Lane choice for each lane clock source, 2 bits per source |
| lane_div4 | input | 2 | Per source: 0 divide by 2, 1 divide by 4 |
| pad_out | output | 16 | Pin output values |
| pad_oe | output | 16 | Pin drive enables |

## Verification
The set and clear writes can land in the same cycle, and the case that matters is a bit named in both masks alongside bits named in only one. The bench raises both strobes together with overlapping masks on a known stored word and expects the overlap to read 0, the set-only bits to read 1 and the untouched bits to stay as they were. The other collision lies in the pin multiplexer. There a pin asks for a lane clock and a generated clock at once, and the bench measures the rising-edge period on the pin to show which source won.

// File: rtl/gpo_pkg.sv
`timescale 1ns/1ps
package gpo_pkg;

    localparam int GEN_CLKS   = 4;
    localparam int GEN_SEL_W  = $clog2(GEN_CLKS);
    localparam int LANE_CLKS  = 4;
    localparam int LANE_PICK_W = $clog2(LANE_CLKS);
    localparam int LANE_SRCS  = 2;
    localparam int LSEL_W     = 2;

    typedef struct packed {
        logic [LSEL_W-1:0]    lane_sel;
        logic                 cg_en;
        logic [GEN_SEL_W-1:0] cg_sel;
        logic                 oe;
    } pin_cfg_t;

    typedef enum logic [1:0] {
        SRC_DATA = 2'd0,
        SRC_GEN  = 2'd1,
        SRC_LANE = 2'd2
    } src_kind_e;

    // Lane request (low select bit) outranks the generated clock,
    // which outranks the stored data bit.
    function automatic src_kind_e pick_source(input pin_cfg_t c);
        if (c.lane_sel[0])
            return SRC_LANE;
        else if (c.cg_en)
            return SRC_GEN;
        else
            return SRC_DATA;
    endfunction

endpackage

// File: rtl/gpo_data_reg.sv
`timescale 1ns/1ps
module gpo_data_reg #(
    parameter int N_PINS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_we,
    input  logic [N_PINS-1:0] set_mask,
    input  logic              clr_we,
    input  logic [N_PINS-1:0] clr_mask,
    output logic [N_PINS-1:0] q
);

    logic [N_PINS-1:0] set_eff;
    logic [N_PINS-1:0] clr_eff;
    logic [N_PINS-1:0] q_next;

    always_comb begin
        set_eff = set_we ? set_mask : '0;
        clr_eff = clr_we ? clr_mask : '0;
        // clear applied after set so an overlapping bit ends at 0
        q_next  = (q | set_eff) & ~clr_eff;
    end

    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else
            q <= q_next;
    end

endmodule

// File: rtl/gpo_lane_div.sv
`timescale 1ns/1ps
module gpo_lane_div
    import gpo_pkg::*;
(
    input  logic                   rst,
    input  logic [LANE_CLKS-1:0]   lane_clk,
    input  logic [LANE_PICK_W-1:0] pick,
    input  logic                   div4,
    output logic                   clk_out
);

    logic       src_clk;
    logic [1:0] cnt;

    assign src_clk = lane_clk[pick];

    always_ff @(posedge src_clk) begin
        if (rst)
            cnt <= '0;
        else
            cnt <= cnt + 2'd1;
    end

    assign clk_out = div4 ? cnt[1] : cnt[0];

endmodule

// File: rtl/gpo_pin_mux.sv
`timescale 1ns/1ps
module gpo_pin_mux
    import gpo_pkg::*;
(
    input  pin_cfg_t              cfg,
    input  logic                  data_bit,
    input  logic [GEN_CLKS-1:0]   gen_clk,
    input  logic [LANE_SRCS-1:0]  lane_src,
    output logic                  pad_out,
    output logic                  pad_oe
);

    src_kind_e kind;
    logic      chosen;

    always_comb begin
        kind = pick_source(cfg);
        unique case (kind)
            SRC_LANE: chosen = lane_src[cfg.lane_sel[1]];
            SRC_GEN:  chosen = gen_clk[cfg.cg_sel];
            default:  chosen = data_bit;
        endcase
        pad_oe  = cfg.oe;
        pad_out = cfg.oe & chosen;
    end

endmodule

// File: rtl/gpo_out_path.sv
`timescale 1ns/1ps
module gpo_out_path
    import gpo_pkg::*;
#(
    parameter int N_PINS = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          set_we,
    input  logic [N_PINS-1:0]             set_mask,
    input  logic                          clr_we,
    input  logic [N_PINS-1:0]             clr_mask,
    output logic [N_PINS-1:0]             rd_data,
    input  logic [N_PINS-1:0]             pin_oe,
    input  logic [N_PINS-1:0]             pin_cgen,
    input  logic [N_PINS*GEN_SEL_W-1:0]   pin_cgsel,
    input  logic [N_PINS*LSEL_W-1:0]      pin_lsel,
    input  logic [GEN_CLKS-1:0]           gen_clk,
    input  logic [LANE_CLKS-1:0]          lane_clk,
    input  logic [LANE_SRCS*LANE_PICK_W-1:0] lane_pick,
    input  logic [LANE_SRCS-1:0]          lane_div4,
    output logic [N_PINS-1:0]             pad_out,
    output logic [N_PINS-1:0]             pad_oe
);

    logic [N_PINS-1:0]    data_q;
    logic [LANE_SRCS-1:0] lane_src;
    pin_cfg_t             cfg_d [N_PINS];
    pin_cfg_t             cfg_q [N_PINS];
    logic [N_PINS-1:0]    data_path_q;

    gpo_data_reg #(.N_PINS(N_PINS)) u_data (
        .clk      (clk),
        .rst      (rst),
        .set_we   (set_we),
        .set_mask (set_mask),
        .clr_we   (clr_we),
        .clr_mask (clr_mask),
        .q        (data_q)
    );

    assign rd_data = data_q;

    for (genvar s = 0; s < LANE_SRCS; s++) begin : g_lane
        gpo_lane_div u_div (
            .rst      (rst),
            .lane_clk (lane_clk),
            .pick     (lane_pick[s*LANE_PICK_W +: LANE_PICK_W]),
            .div4     (lane_div4[s]),
            .clk_out  (lane_src[s])
        );
    end

    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
        always_comb begin
            cfg_d[i].oe       = pin_oe[i];
            cfg_d[i].cg_en    = pin_cgen[i];
            cfg_d[i].cg_sel   = pin_cgsel[i*GEN_SEL_W +: GEN_SEL_W];
            cfg_d[i].lane_sel = pin_lsel[i*LSEL_W +: LSEL_W];
        end

        always_ff @(posedge clk) begin
            if (rst)
                cfg_q[i] <= '0;
            else
                cfg_q[i] <= cfg_d[i];
        end

        assign data_path_q[i] = cfg_q[i].oe & (pick_source(cfg_q[i]) == SRC_DATA);

        gpo_pin_mux u_mux (
            .cfg      (cfg_q[i]),
            .data_bit (data_q[i]),
            .gen_clk  (gen_clk),
            .lane_src (lane_src),
            .pad_out  (pad_out[i]),
            .pad_oe   (pad_oe[i])
        );
    end

endmodule

// File: rtl/gpo_out_path_chk.sv
`timescale 1ns/1ps
module gpo_out_path_chk #(
    parameter int N_PINS = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              set_we,
    input logic [N_PINS-1:0] set_mask,
    input logic              clr_we,
    input logic [N_PINS-1:0] clr_mask,
    input logic [N_PINS-1:0] rd_data,
    input logic [N_PINS-1:0] pad_out,
    input logic [N_PINS-1:0] pad_oe,
    input logic [N_PINS-1:0] data_path_q
);

    logic [N_PINS-1:0] set_only;
    assign set_only = set_mask & ~(clr_we ? clr_mask : '0);

    // R1: set-only bits read 1 after the edge
    a_r1_set_bits: assert property (@(posedge clk) disable iff (rst)
        set_we |=> ((rd_data & $past(set_only)) == $past(set_only)));

    // R2: cleared bits read 0 after the edge
    a_r2_clr_bits: assert property (@(posedge clk) disable iff (rst)
        clr_we |=> ((rd_data & $past(clr_mask)) == '0));

    // R3: overlap of both masks ends at 0
    a_r3_clear_wins: assert property (@(posedge clk) disable iff (rst)
        (set_we && clr_we) |=> ((rd_data & $past(set_mask & clr_mask)) == '0));

    // R4: no strobe, no change
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
        (!set_we && !clr_we) |=> $stable(rd_data));

    // R5: an undriven pin outputs 0
    a_r5_undriven_low: assert property (@(posedge clk) disable iff (rst)
        ((pad_out & ~pad_oe) == '0));

    // R6: data-sourced pins mirror the stored word
    a_r6_data_follow: assert property (@(posedge clk) disable iff (rst)
        (((pad_out ^ rd_data) & data_path_q) == '0));

endmodule

bind gpo_out_path gpo_out_path_chk #(.N_PINS(N_PINS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .set_we      (set_we),
    .set_mask    (set_mask),
    .clr_we      (clr_we),
    .clr_mask    (clr_mask),
    .rd_data     (rd_data),
    .pad_out     (pad_out),
    .pad_oe      (pad_oe),
    .data_path_q (data_path_q)
);

// File: tb/tb_gpo_out_path.sv
`timescale 1ns/1ps
module tb_gpo_out_path;

    localparam int  N      = 16;
    localparam time CLK_P  = 10;

    logic          clk = 0;
    logic          rst = 1;
    logic          set_we = 0, clr_we = 0;
    logic [N-1:0]  set_mask = '0, clr_mask = '0;
    logic [N-1:0]  rd_data;
    logic [N-1:0]  pin_oe = '0, pin_cgen = '0;
    logic [2*N-1:0] pin_cgsel = '0, pin_lsel = '0;
    logic [3:0]    gen_clk = '0, lane_clk = '0;
    logic [3:0]    lane_pick = '0;
    logic [1:0]    lane_div4 = '0;
    logic [N-1:0]  pad_out, pad_oe;

    int n_checks = 0;
    int n_fail   = 0;

    gpo_out_path #(.N_PINS(N)) dut (
        .clk(clk), .rst(rst),
        .set_we(set_we), .set_mask(set_mask),
        .clr_we(clr_we), .clr_mask(clr_mask),
        .rd_data(rd_data),
        .pin_oe(pin_oe), .pin_cgen(pin_cgen),
        .pin_cgsel(pin_cgsel), .pin_lsel(pin_lsel),
        .gen_clk(gen_clk), .lane_clk(lane_clk),
        .lane_pick(lane_pick), .lane_div4(lane_div4),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    always #(CLK_P/2) clk = ~clk;
    // generated clocks: periods 4, 6, 10, 14 ns
    always #2 gen_clk[0] = ~gen_clk[0];
    always #3 gen_clk[1] = ~gen_clk[1];
    always #5 gen_clk[2] = ~gen_clk[2];
    always #7 gen_clk[3] = ~gen_clk[3];
    // lane clocks: periods 6, 8, 12, 14 ns
    always #3 lane_clk[0] = ~lane_clk[0];
    always #4 lane_clk[1] = ~lane_clk[1];
    always #6 lane_clk[2] = ~lane_clk[2];
    always #7 lane_clk[3] = ~lane_clk[3];

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_pin(input int p, input bit oe, input bit cg,
                           input logic [1:0] cgs, input logic [1:0] ls);
        pin_oe[p]          = oe;
        pin_cgen[p]        = cg;
        pin_cgsel[2*p +: 2] = cgs;
        pin_lsel[2*p +: 2]  = ls;
    endtask

    task automatic write_masks(input bit sw, input logic [N-1:0] sm,
                               input bit cw, input logic [N-1:0] cm);
        @(negedge clk);
        set_we = sw; set_mask = sm; clr_we = cw; clr_mask = cm;
        @(negedge clk);
        set_we = 0; clr_we = 0; set_mask = '0; clr_mask = '0;
    endtask

    task automatic settle_cfg;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic rise_period(input int p, output time dt);
        time t0;
        for (int k = 0; k < 2; k++) begin
            wait (pad_out[p] == 1'b0);
            wait (pad_out[p] == 1'b1);
        end
        t0 = $time;
        wait (pad_out[p] == 1'b0);
        wait (pad_out[p] == 1'b1);
        dt = $time - t0;
    endtask

    task automatic t_reset;
        pin_oe = '1;
        repeat (3) @(negedge clk);
        chk(rd_data == '0, "R10 data in reset", rd_data, 0);
        chk(pad_oe == '0, "R10 pad_oe in reset", pad_oe, 0);
        rst = 0;
        pin_oe = '0;
        settle_cfg();
    endtask

    task automatic t_set_clear;
        write_masks(1, 16'h00F3, 0, '0);
        chk(rd_data == 16'h00F3, "R1 set", rd_data, 16'h00F3);
        write_masks(1, 16'h0F00, 0, '0);
        chk(rd_data == 16'h0FF3, "R4 unmasked kept on set", rd_data, 16'h0FF3);
        write_masks(0, '0, 1, 16'h0033);
        chk(rd_data == 16'h0FC0, "R2 clear", rd_data, 16'h0FC0);
    endtask

    task automatic t_collision;
        write_masks(1, 16'hA005, 1, 16'h0005);
        chk(rd_data == 16'hAFC0, "R3 clear wins overlap", rd_data, 16'hAFC0);
    endtask

    task automatic t_hold;
        @(negedge clk);
        set_mask = 16'h5000; clr_mask = 16'h0FC0;
        repeat (3) @(negedge clk);
        chk(rd_data == 16'hAFC0, "R4 masks without strobe ignored", rd_data, 16'hAFC0);
        set_mask = '0; clr_mask = '0;
    endtask

    task automatic t_oe_data;
        for (int p = 0; p < N; p++) set_pin(p, 0, 0, 2'd0, 2'd0);
        settle_cfg();
        chk(pad_oe == '0, "R5 pad_oe off", pad_oe, 0);
        chk(pad_out == '0, "R5 pad_out low when undriven", pad_out, 0);
        for (int p = 0; p < 8; p++) set_pin(p, 1, 0, 2'd0, 2'd0);
        set_pin(9, 0, 0, 2'd0, 2'd2);
        settle_cfg();
        chk(pad_oe == 16'h00FF, "R5 pad_oe follows enable", pad_oe, 16'h00FF);
        chk(pad_out == 16'h00C0, "R6 data on pins", pad_out, 16'h00C0);
        write_masks(1, 16'h0001, 1, 16'h0040);
        chk(pad_out == 16'h0081, "R6 pins follow new data", pad_out, 16'h0081);
        set_pin(1, 1, 0, 2'd3, 2'd2);
        settle_cfg();
        chk(pad_out[1] == 1'b0, "R8 select 10 is normal data", pad_out[1], 0);
    endtask

    task automatic t_genclk;
        int bad = 0;
        set_pin(2, 1, 1, 2'd1, 2'd0);
        set_pin(7, 1, 1, 2'd3, 2'd2);
        set_pin(12, 0, 1, 2'd0, 2'd0);
        settle_cfg();
        #0.5;
        for (int k = 0; k < 16; k++) begin
            if (pad_out[2] !== gen_clk[1]) bad++;
            if (pad_out[7] !== gen_clk[3]) bad++;
            if (pad_out[12] !== 1'b0) bad++;
            #2;
        end
        chk(bad == 0, "R7 generated clock on pins", bad, 0);
    endtask

    task automatic t_lane;
        time dt;
        @(negedge clk);
        lane_pick = {2'd1, 2'd2};
        lane_div4 = 2'b10;
        set_pin(3, 1, 0, 2'd0, 2'b01);
        set_pin(4, 1, 1, 2'd2, 2'b11);
        settle_cfg();
        rise_period(3, dt);
        chk(dt == 24, "R9 source0 lane2 div2", dt, 24);
        rise_period(4, dt);
        chk(dt == 32, "R8 lane over gen, R9 source1 lane1 div4", dt, 32);
        @(negedge clk);
        lane_pick = {2'd1, 2'd3};
        lane_div4 = 2'b11;
        settle_cfg();
        rise_period(3, dt);
        chk(dt == 56, "R9 source0 lane3 div4", dt, 56);
        @(negedge clk);
        lane_pick = {2'd0, 2'd3};
        lane_div4 = 2'b00;
        settle_cfg();
        rise_period(4, dt);
        chk(dt == 12, "R9 source1 lane0 div2", dt, 12);
        set_pin(4, 1, 1, 2'd2, 2'b10);
        settle_cfg();
        rise_period(4, dt);
        chk(dt == 10, "R8 select x0 gives generated clock", dt, 10);
    endtask

    initial begin : watchdog
        #(CLK_P * 20000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        t_reset();
        t_set_clear();
        t_collision();
        t_hold();
        t_oe_data();
        t_genclk();
        t_lane();
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule